// File: doc/BRIEF.md
# Seven-Level Priority Interrupt Controller

This block arbitrates interrupts among seven priority levels, numbered 1 to 7, with level 1 the most urgent. Each level takes a hardware request line and a software request bit. A level can interrupt only when all of these hold:

- the system is switched on;
- the level is enabled;
- the level has a request;
- no level of equal or higher priority is being serviced.

When a level is granted, the block marks it in progress. For one cycle it presents the level number and the address of that level's two-word service slot, which is octal 40 plus twice the level number.

Software drives the block with a single command word. A seven-bit mask picks the levels, and separate action bits say what to do with them. The actions can enable or disable levels, and raise or drop software requests. Other actions switch the whole system on or off, or reset the whole controller. A status word reports, in separate fields:

- the enabled levels;
- the system-on flag;
- the in-progress levels;
- the software requests.

The service routine ends with a one-cycle dismiss pulse. The pulse retires the most urgent level in progress, which lets lower levels through again.

Hardware request lines are level-sensitive and assumed synchronous to `clk`. A request that stays high after its service is dismissed is granted again.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After a synchronous active-low reset, the status word is zero and no grant is presented.
- R2: Command bit 11 sets the software request of every masked level, and bit 12 clears it. When both bits are set in one command, clearing wins. Software requests occupy status bits 21:15, with bit 15 for level 1. A software request stays set until it is dropped.
- R3: Command bit 10 enables the masked levels and bit 9 disables them. Levels outside the mask keep their enable. Enables occupy status bits 6:0, with bit 0 for level 1.
- R4: A grant raises `grant_valid` for one cycle per grant. During that cycle `grant_level` carries the level number (1 to 7) and `grant_vector` carries 32 + 2×level.
- R5: No level is granted while the system-on flag (status bit 7) is clear. No level is granted while its enable is clear.
- R6: A grant sets the level's in-progress bit in status bits 14:8, with bit 8 for level 1. While a level is in progress, no level of equal or lower priority is granted, but a higher-priority level is.
- R7: Among eligible levels, the lowest-numbered level is granted. The grant appears on the clock edge after the request, enable and system-on state it depends on.
- R8: A dismiss pulse clears the lowest-numbered in-progress bit. When nothing is in progress, dismiss has no effect.
- R9: Command bit 13 clears the enables, the software requests, the in-progress bits and the system-on flag in one cycle. No grant is issued on that edge.
- R10: Command bit 8 switches the system off and bit 7 switches it on. When both bits are set, off wins. The same rule applies when the enable and disable bits (10 and 9) are both set for a level.
- R11: The command word carries the level mask in bits 6:0, with bit 0 for level 1. A command acts only when `cmd_valid` is high, and its effect is visible in the status word on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command word is applied this cycle |
| cmd_word | input | 14 | Level mask (6:0) and action bits (13:7) |
| hw_req | input | 7 | Hardware request per level, bit 0 = level 1 |
| dismiss | input | 1 | End service of the most urgent in-progress level |
| status_word | output | 22 | Software requests, in-progress, system-on, enables |
| grant_valid | output | 1 | A level is granted this cycle |
| grant_level | output | 3 | Granted level number, 1 to 7 |
| grant_vector | output | 9 | Service slot address of the granted level |

## Verification
The main function is tried with a single hardware request, a request that arrives while a lower level is in service, and a request that arrives while a higher level is in service. It is also tried with two simultaneous requests and with software-initiated requests. Together these separate pure priority choice from blocking by the in-progress set. The dismiss sequences show that only the most urgent in-progress level is retired, which is what releases the blocked lower levels one at a time. Commands that set and clear the same target in one word, and a reset of the whole controller while a level is in service, pin down which action dominates.

// File: rtl/pic_pkg.sv
// Package: shared widths, command and status field positions, and helper
// functions for the priority interrupt controller.
// Assumes level 1 maps to bit 0 of every per-level vector.
package pic_pkg;

    localparam int LVL_N   = 7;
    localparam int LVL_W   = $clog2(LVL_N + 1);

    // Command word layout: mask in the low bits, then one bit per action.
    localparam int CMD_SYS_ON  = LVL_N;
    localparam int CMD_SYS_OFF = LVL_N + 1;
    localparam int CMD_LVL_OFF = LVL_N + 2;
    localparam int CMD_LVL_ON  = LVL_N + 3;
    localparam int CMD_INIT    = LVL_N + 4;
    localparam int CMD_DROP    = LVL_N + 5;
    localparam int CMD_CLEAR   = LVL_N + 6;
    localparam int CMD_W       = LVL_N + 7;

    // Status word layout: enables, system flag, in-progress, soft requests.
    localparam int ST_EN_LO    = 0;
    localparam int ST_SYS      = LVL_N;
    localparam int ST_IP_LO    = LVL_N + 1;
    localparam int ST_SW_LO    = 2 * LVL_N + 1;
    localparam int ST_W        = 3 * LVL_N + 1;

    typedef logic [LVL_N-1:0] lvl_vec_t;

    // Decoded command actions for one cycle.
    typedef struct packed {
        lvl_vec_t mask;
        logic     sys_on;
        logic     sys_off;
        logic     lvl_off;
        logic     lvl_on;
        logic     init;
        logic     drop;
        logic     clear;
    } pic_cmd_t;

    // Keep only the lowest set bit of a level vector.
    function automatic lvl_vec_t lowest_bit(input lvl_vec_t v);
        return v & (~v + lvl_vec_t'(1));
    endfunction

    // Convert a one-hot level vector to a level number (1-based, 0 if none).
    function automatic logic [LVL_W-1:0] onehot_to_lvl(input lvl_vec_t v);
        logic [LVL_W-1:0] n;
        n = '0;
        for (int i = 0; i < LVL_N; i++) begin
            if (v[i]) n = n | LVL_W'(i + 1);
        end
        return n;
    endfunction

endpackage

// File: rtl/pic_cmd_decode.sv
// Module: splits a raw command word into mask and action fields.
// Assumes the field positions in pic_pkg; every action is gated by valid.
module pic_cmd_decode
    import pic_pkg::*;
(
    input  logic             cmd_valid,
    input  logic [CMD_W-1:0] cmd_word,
    output pic_cmd_t         cmd
);

    // Field extraction with actions masked when no command is present.
    always_comb begin
        cmd.mask    = cmd_word[LVL_N-1:0];
        cmd.sys_on  = cmd_valid & cmd_word[CMD_SYS_ON];
        cmd.sys_off = cmd_valid & cmd_word[CMD_SYS_OFF];
        cmd.lvl_off = cmd_valid & cmd_word[CMD_LVL_OFF];
        cmd.lvl_on  = cmd_valid & cmd_word[CMD_LVL_ON];
        cmd.init    = cmd_valid & cmd_word[CMD_INIT];
        cmd.drop    = cmd_valid & cmd_word[CMD_DROP];
        cmd.clear   = cmd_valid & cmd_word[CMD_CLEAR];
    end

endmodule

// File: rtl/pic_ctrl_regs.sv
// Module: holds the level enables, software requests and system-on flag
// and applies decoded commands to them.
// Assumes clear dominates all other actions and removal beats setting.
module pic_ctrl_regs
    import pic_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  pic_cmd_t cmd,
    output lvl_vec_t en_q,
    output lvl_vec_t sw_q,
    output logic     sys_q
);

    lvl_vec_t en_d, sw_d;
    logic     sys_d;

    // Next-state: set then remove, so removal wins on a shared target.
    always_comb begin
        en_d  = en_q;
        sw_d  = sw_q;
        sys_d = sys_q;
        if (cmd.lvl_on)  en_d = en_d | cmd.mask;
        if (cmd.lvl_off) en_d = en_d & ~cmd.mask;
        if (cmd.init)    sw_d = sw_d | cmd.mask;
        if (cmd.drop)    sw_d = sw_d & ~cmd.mask;
        if (cmd.sys_on)  sys_d = 1'b1;
        if (cmd.sys_off) sys_d = 1'b0;
        if (cmd.clear) begin
            en_d  = '0;
            sw_d  = '0;
            sys_d = 1'b0;
        end
    end

    // State registers with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q  <= '0;
            sw_q  <= '0;
            sys_q <= 1'b0;
        end else begin
            en_q  <= en_d;
            sw_q  <= sw_d;
            sys_q <= sys_d;
        end
    end

endmodule

// File: rtl/pic_arbiter.sv
// Module: picks the most urgent eligible level from the current state.
// Assumes lower bit index means higher priority; purely combinational.
module pic_arbiter
    import pic_pkg::*;
(
    input  lvl_vec_t hw_req,
    input  lvl_vec_t sw_req,
    input  lvl_vec_t en,
    input  logic     sys_on,
    input  lvl_vec_t in_prog,
    input  logic     clear,
    output logic     win_valid,
    output lvl_vec_t win_onehot
);

    lvl_vec_t blocked;
    lvl_vec_t eligible;

    // Blocked if this level or any more urgent level is in progress.
    generate
        for (genvar i = 0; i < LVL_N; i++) begin : g_block
            if (i == 0) begin : g_first
                assign blocked[i] = in_prog[i];
            end else begin : g_rest
                assign blocked[i] = in_prog[i] | blocked[i-1];
            end
        end
    endgenerate

    // Eligibility and selection of the lowest-numbered candidate.
    always_comb begin
        eligible   = (hw_req | sw_req) & en & {LVL_N{sys_on}} & ~blocked;
        win_onehot = clear ? '0 : lowest_bit(eligible);
        win_valid  = |win_onehot;
    end

endmodule

// File: rtl/pic_inprog.sv
// Module: tracks the in-progress set; grants add a level, dismiss retires
// the most urgent one, clear empties it.
// Assumes a granted level is never already in progress.
module pic_inprog
    import pic_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  lvl_vec_t grant_onehot,
    input  logic     dismiss,
    input  logic     clear,
    output lvl_vec_t in_prog_q
);

    lvl_vec_t in_prog_d;

    // Next-state: retire most urgent on dismiss, then add the new grant.
    always_comb begin
        in_prog_d = in_prog_q;
        if (dismiss) in_prog_d = in_prog_d & ~lowest_bit(in_prog_q);
        in_prog_d = in_prog_d | grant_onehot;
        if (clear)   in_prog_d = '0;
    end

    // In-progress register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) in_prog_q <= '0;
        else        in_prog_q <= in_prog_d;
    end

endmodule

// File: rtl/prio_irq_ctrl.sv
// Module: seven-level priority interrupt controller top. Decodes commands,
// holds control state, arbitrates, tracks service and registers the grant.
// Assumes hw_req is synchronous to clk and level-sensitive.
module prio_irq_ctrl
    import pic_pkg::*;
#(
    parameter int VEC_BASE = 32,
    parameter int VEC_W    = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic [CMD_W-1:0] cmd_word,
    input  logic [LVL_N-1:0] hw_req,
    input  logic             dismiss,
    output logic [ST_W-1:0]  status_word,
    output logic             grant_valid,
    output logic [LVL_W-1:0] grant_level,
    output logic [VEC_W-1:0] grant_vector
);

    pic_cmd_t cmd;
    lvl_vec_t en_q, sw_q, in_prog_q, win_onehot;
    logic     sys_q, win_valid;
    logic [LVL_W-1:0] win_lvl;

    pic_cmd_decode i_dec (
        .cmd_valid (cmd_valid),
        .cmd_word  (cmd_word),
        .cmd       (cmd)
    );

    pic_ctrl_regs i_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .cmd   (cmd),
        .en_q  (en_q),
        .sw_q  (sw_q),
        .sys_q (sys_q)
    );

    pic_arbiter i_arb (
        .hw_req     (hw_req),
        .sw_req     (sw_q),
        .en         (en_q),
        .sys_on     (sys_q),
        .in_prog    (in_prog_q),
        .clear      (cmd.clear),
        .win_valid  (win_valid),
        .win_onehot (win_onehot)
    );

    pic_inprog i_ip (
        .clk          (clk),
        .rst_n        (rst_n),
        .grant_onehot (win_onehot),
        .dismiss      (dismiss),
        .clear        (cmd.clear),
        .in_prog_q    (in_prog_q)
    );

    // Level number of the winner.
    always_comb win_lvl = onehot_to_lvl(win_onehot);

    // Registered grant outputs: one cycle per grant.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            grant_valid  <= 1'b0;
            grant_level  <= '0;
            grant_vector <= '0;
        end else begin
            grant_valid  <= win_valid;
            grant_level  <= win_valid ? win_lvl : '0;
            grant_vector <= win_valid ? VEC_W'(VEC_BASE + 2 * int'(win_lvl)) : '0;
        end
    end

    // Status word assembly.
    always_comb begin
        status_word = '0;
        status_word[ST_EN_LO +: LVL_N] = en_q;
        status_word[ST_SYS]            = sys_q;
        status_word[ST_IP_LO +: LVL_N] = in_prog_q;
        status_word[ST_SW_LO +: LVL_N] = sw_q;
    end

endmodule

// File: rtl/pic_checker.sv
// Module: property checks on the controller ports, bound to the top.
// Assumes the status and command layouts from pic_pkg.
module pic_checker
    import pic_pkg::*;
#(
    parameter int VEC_BASE = 32,
    parameter int VEC_W    = 9
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cmd_valid,
    input logic [CMD_W-1:0] cmd_word,
    input logic             dismiss,
    input logic [ST_W-1:0]  status_word,
    input logic             grant_valid,
    input logic [LVL_W-1:0] grant_level,
    input logic [VEC_W-1:0] grant_vector
);

    logic [LVL_N-1:0] ip_now;
    logic             is_clear;
    assign ip_now   = status_word[ST_IP_LO +: LVL_N];
    assign is_clear = cmd_valid & cmd_word[CMD_CLEAR];

    // R4
    vector_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid |-> (grant_level >= 1 && grant_level <= LVL_N &&
                         int'(grant_vector) == VEC_BASE + 2 * int'(grant_level)));

    // R6
    granted_in_prog_chk: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid |-> ip_now[grant_level - 1]);

    // R5
    sys_off_no_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !status_word[ST_SYS] |=> !grant_valid);

    // R9
    clear_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        is_clear |=> (status_word == '0 && !grant_valid));

    // R10
    sys_off_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_word[CMD_SYS_OFF]) |=> !status_word[ST_SYS]);

    // R8
    dismiss_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dismiss && ip_now != '0 && !is_clear) |=>
        ($countones(ip_now) == $countones($past(ip_now)) - 1 + int'(grant_valid)));

endmodule

bind prio_irq_ctrl pic_checker #(.VEC_BASE(VEC_BASE), .VEC_W(VEC_W)) i_pic_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cmd_valid    (cmd_valid),
    .cmd_word     (cmd_word),
    .dismiss      (dismiss),
    .status_word  (status_word),
    .grant_valid  (grant_valid),
    .grant_level  (grant_level),
    .grant_vector (grant_vector)
);

// File: tb/test_prio_irq_ctrl.sv
// Bench: scoreboard of expected grants plus direct status-word checks.
module test_prio_irq_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam logic [13:0] C_SYS_ON  = 14'h0080;
    localparam logic [13:0] C_SYS_OFF = 14'h0100;
    localparam logic [13:0] C_LVL_OFF = 14'h0200;
    localparam logic [13:0] C_LVL_ON  = 14'h0400;
    localparam logic [13:0] C_INIT    = 14'h0800;
    localparam logic [13:0] C_DROP    = 14'h1000;
    localparam logic [13:0] C_CLEAR   = 14'h2000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [13:0] cmd_word = '0;
    logic [6:0]  hw_req = '0;
    logic        dismiss = 1'b0;
    logic [21:0] status_word;
    logic        grant_valid;
    logic [2:0]  grant_level;
    logic [8:0]  grant_vector;

    int n_tests = 0;
    int n_fail  = 0;
    int exp_q[$];
    bit done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    prio_irq_ctrl i_prio_irq_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .cmd_valid    (cmd_valid),
        .cmd_word     (cmd_word),
        .hw_req       (hw_req),
        .dismiss      (dismiss),
        .status_word  (status_word),
        .grant_valid  (grant_valid),
        .grant_level  (grant_level),
        .grant_vector (grant_vector)
    );

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic send(input logic [13:0] w);
        cmd_valid = 1'b1;
        cmd_word  = w;
        tick();
        cmd_valid = 1'b0;
        cmd_word  = '0;
    endtask

    task automatic expect_grant(input int lvl);
        exp_q.push_back(lvl);
    endtask

    task automatic chk_status(input logic [21:0] exp, input string req);
        n_tests++;
        if (status_word !== exp) begin
            n_fail++;
            $display("FAIL %s status actual=%h expected=%h", req, status_word, exp);
        end
    endtask

    task automatic pulse_dismiss();
        dismiss = 1'b1;
        tick();
        dismiss = 1'b0;
    endtask

    // Monitor: compare every grant against the scoreboard (R4, R7).
    always @(negedge clk) begin
        if (rst_n && grant_valid && !done) begin
            n_tests++;
            if (exp_q.size() == 0) begin
                n_fail++;
                $display("FAIL R4 unexpected grant actual=%0d expected=none", grant_level);
            end else begin
                int e;
                e = exp_q.pop_front();
                if (int'(grant_level) != e || int'(grant_vector) != 32 + 2 * e) begin
                    n_fail++;
                    $display("FAIL R7 grant actual=%0d/%0d expected=%0d/%0d",
                             grant_level, grant_vector, e, 32 + 2 * e);
                end
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) tick();
        // R1: reset state
        chk_status(22'h0, "R1");
        n_tests++;
        if (grant_valid !== 1'b0) begin
            n_fail++;
            $display("FAIL R1 grant_valid actual=%b expected=0", grant_valid);
        end
        rst_n = 1'b1;
        tick();
        chk_status(22'h0, "R1");

        // R3, R11: enable all levels, system still off
        send(C_LVL_ON | 14'h7F);
        chk_status(22'h00007F, "R3");

        // R5: request while system off gives no grant
        hw_req = 7'h04;
        tick(); tick();
        chk_status(22'h00007F, "R5");

        // R7: switch system on, level 3 granted one edge later
        expect_grant(3);
        send(C_SYS_ON);
        tick();
        hw_req = 7'h00;
        tick();
        chk_status(22'h0004FF, "R6");

        // R6: lower level 5 blocked, higher level 2 preempts
        hw_req = 7'h10;
        tick(); tick();
        expect_grant(2);
        hw_req = 7'h12;
        tick();
        hw_req = 7'h10;
        tick();
        chk_status(22'h0006FF, "R6");

        // R8: dismiss retires level 2 first, then level 3, releasing 5
        pulse_dismiss();
        chk_status(22'h0004FF, "R8");
        expect_grant(5);
        pulse_dismiss();
        tick();
        hw_req = 7'h00;
        chk_status(22'h0010FF, "R8");
        pulse_dismiss();
        chk_status(22'h0000FF, "R8");
        pulse_dismiss();
        chk_status(22'h0000FF, "R8");

        // R2: software requests on levels 1 and 7
        expect_grant(1);
        send(C_INIT | 14'h41);
        tick();
        chk_status(22'h2081FF, "R2");
        send(C_DROP | 14'h01);
        chk_status(22'h2001FF, "R2");
        expect_grant(7);
        pulse_dismiss();
        tick();
        chk_status(22'h2040FF, "R2");
        dismiss = 1'b1;
        send(C_DROP | 14'h40);
        dismiss = 1'b0;
        chk_status(22'h0000FF, "R2");

        // R7: simultaneous levels 4 and 6, level 4 first
        expect_grant(4);
        hw_req = 7'h28;
        tick();
        hw_req = 7'h20;
        expect_grant(6);
        pulse_dismiss();
        tick();
        hw_req = 7'h00;
        pulse_dismiss();
        chk_status(22'h0000FF, "R7");

        // R3, R5: disabled level 3 is not granted
        send(C_LVL_OFF | 14'h04);
        chk_status(22'h0000FB, "R3");
        hw_req = 7'h04;
        tick(); tick();
        // R10: enable and disable together leaves it disabled
        send(C_LVL_ON | C_LVL_OFF | 14'h04);
        tick();
        chk_status(22'h0000FB, "R10");
        hw_req = 7'h00;
        send(C_SYS_ON | C_SYS_OFF);
        chk_status(22'h00007B, "R10");

        // R9: clear everything with a level in progress
        send(C_INIT | 14'h7F);
        chk_status(22'h3F807B, "R2");
        expect_grant(1);
        send(C_SYS_ON);
        chk_status(22'h3F80FB, "R5");
        tick();
        chk_status(22'h3F81FB, "R6");
        send(C_CLEAR);
        chk_status(22'h000000, "R9");
        tick();

        // R2: initiate and drop in one command, drop wins
        send(C_INIT | C_DROP | 14'h08);
        chk_status(22'h000000, "R2");
        // R11: empty mask changes nothing
        send(C_LVL_ON);
        chk_status(22'h000000, "R11");
        // R11: command bits ignored without cmd_valid
        cmd_word = C_LVL_ON | 14'h7F;
        tick();
        cmd_word = '0;
        chk_status(22'h000000, "R11");
        tick();

        n_tests++;
        if (exp_q.size() != 0) begin
            n_fail++;
            $display("FAIL R4 pending grants actual=%0d expected=0", exp_q.size());
        end
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule